// File: doc/BRIEF.md
# Programmable CRC-32 Register Engine

This block is a CRC accelerator that sits on a simple 32-bit register bus with address, write strobe, write data, read strobe and read data. It keeps one 32-bit accumulator. Every write to the data register folds a whole 32-bit word into the accumulator in a single clock, using a generator polynomial that software programs at run time. The accumulator starts from a software-programmed seed, and software reloads it through a control register.

The engine always works MSB-first. Two control options let the same datapath produce reflected checksums. One reflects the incoming word within bytes, halfwords or the whole word. The other reverses the accumulator bits when it is read. With the whole-word input reflection and the output reversal both on, the reflected CRC-32 is read out directly. The same setting gives the complement of CRC-32C. The engine never inverts its result, so software applies any final XOR.

Top module: `prog_crc32_engine`

## Requirements
- R1: After reset the data register reads 0xFFFFFFFF, the control register reads 0, the seed register reads 0xFFFFFFFF and the polynomial register reads 0x04C11DB7.
- R2: A write to offset 0x00 updates the accumulator at that clock edge. For each bit of the (possibly reflected) word, MSB first, it shifts the accumulator left by one and XORs in the polynomial when the bit leaving the top differs from the data bit. A read issued in the next cycle returns the new value.
- R3: Writing control offset 0x08 with bit 0 set copies the seed register into the accumulator at that edge. Bit 0 and bits 4:1 of the control register always read as 0.
- R4: Control bits 6:5 select the input reflection applied before folding: 0 none, 1 within each byte, 2 within each 16-bit half, 3 across the whole 32-bit word.
- R5: Control bit 7 makes a data-register read return the accumulator with its 32 bits reversed. The accumulator itself is left unchanged.
- R6: With control bits 7:5 all set, polynomial 0x04C11DB7 and seed 0xFFFFFFFF, the data register reads the reflected CRC-32 register state of the little-endian words written, with no inversion.
- R7: With control bits 7:5 all set, polynomial 0x1EDC6F41 and seed 0xFFFFFFFF, the bitwise inverse of the data read equals the standard CRC-32C of the words written.
- R8: Writes to the polynomial register, the seed register, or to the control register with bit 0 clear leave the accumulator unchanged. New polynomial and reflection settings apply from the next data write.
- R9: Reads from any offset other than 0x00, 0x08, 0x10 and 0x14 return 0. Writes to those offsets change no register.
- R10: The seed register (offset 0x10) and the polynomial register (offset 0x14) read back the last value written.
- R11: Read data is registered. It updates at the clock edge where the read strobe is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the register accessed |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | CRC_W (32) | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | CRC_W (32) | Registered read data |

## Verification
The fold is tried under all eight reflection settings against several data patterns: all zeros, all ones, alternating bits, a single set bit at each end and mixed words. These show whether each reflection lane is wired the right way round, because an asymmetric word only matches the model when its bit order is right. The two fully reflected cases run word sequences against a bit-serial LSB-first model with the reflected polynomials, which checks the claimed equivalence rather than the engine's own formulation. Every byte offset is swept for both reads and writes to separate the four decoded registers from unmapped space. Mid-stream writes of the polynomial, seed and control register show that configuration changes and reloads act only where they should.

// File: rtl/pcrc_pkg.sv
package pcrc_pkg;

   // input reflection selector (control bits 6:5)
   typedef enum logic [1:0] {
      IN_REV_NONE = 2'd0,
      IN_REV_BYTE = 2'd1,
      IN_REV_HALF = 2'd2,
      IN_REV_WORD = 2'd3
   } in_rev_e;

   // control register field positions
   localparam int CTRL_RELOAD_BIT = 0;
   localparam int CTRL_MODE_LSB   = 5;
   localparam int CTRL_MODE_W     = 3;

   typedef struct packed {
      logic    out_rev;
      in_rev_e in_rev;
   } crc_mode_t;

endpackage

// File: rtl/pcrc_lane_reflect.sv
module pcrc_lane_reflect #(
   parameter int W    = 32,
   parameter int LANE = 8
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   localparam int N_LANES = W / LANE;

   generate
      if (LANE < 1 || (W % LANE) != 0) begin : g_bad_lane
         $error("pcrc_lane_reflect: LANE must divide W");
      end
      for (genvar g = 0; g < N_LANES; g++) begin : g_lane
         for (genvar b = 0; b < LANE; b++) begin : g_bit
            assign dout[g*LANE + b] = din[g*LANE + LANE - 1 - b];
         end
      end
   endgenerate
endmodule

// File: rtl/pcrc_in_swizzle.sv
module pcrc_in_swizzle
   import pcrc_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] din,
   input  in_rev_e      mode,
   output logic [W-1:0] dout
);
   logic [W-1:0] rev_byte;
   logic [W-1:0] rev_half;
   logic [W-1:0] rev_word;

   generate
      if ((W % 16) != 0) begin : g_bad_w
         $error("pcrc_in_swizzle: W must be a multiple of 16");
      end
   endgenerate

   pcrc_lane_reflect #(.W(W), .LANE(8))  u_rev_byte (.din(din), .dout(rev_byte));
   pcrc_lane_reflect #(.W(W), .LANE(16)) u_rev_half (.din(din), .dout(rev_half));
   pcrc_lane_reflect #(.W(W), .LANE(W))  u_rev_word (.din(din), .dout(rev_word));

   always_comb begin
      unique case (mode)
         IN_REV_BYTE: dout = rev_byte;
         IN_REV_HALF: dout = rev_half;
         IN_REV_WORD: dout = rev_word;
         default:     dout = din;
      endcase
   end
endmodule

// File: rtl/pcrc_fold.sv
module pcrc_fold #(
   parameter int W = 32
) (
   input  logic [W-1:0] crc_in,
   input  logic [W-1:0] data,
   input  logic [W-1:0] poly,
   output logic [W-1:0] crc_out
);
   // stage[k] is the register state after k data bits, MSB first
   logic [W:0][W-1:0] stage;

   assign stage[0] = crc_in;

   generate
      for (genvar k = 0; k < W; k++) begin : g_step
         logic fb;
         assign fb           = stage[k][W-1] ^ data[W-1-k];
         assign stage[k+1]   = {stage[k][W-2:0], 1'b0} ^ (fb ? poly : '0);
      end
   endgenerate

   assign crc_out = stage[W];
endmodule

// File: rtl/prog_crc32_engine.sv
module prog_crc32_engine
   import pcrc_pkg::*;
#(
   parameter int            ADDR_W   = 8,
   parameter int            CRC_W    = 32,
   parameter int unsigned   OFS_DATA = 'h00,
   parameter int unsigned   OFS_CTRL = 'h08,
   parameter int unsigned   OFS_SEED = 'h10,
   parameter int unsigned   OFS_POLY = 'h14,
   parameter logic [31:0]   SEED_RST = 32'hFFFF_FFFF,
   parameter logic [31:0]   POLY_RST = 32'h04C1_1DB7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr_en,
   input  logic [CRC_W-1:0]  bus_wdata,
   input  logic              bus_rd_en,
   output logic [CRC_W-1:0]  bus_rdata
);
   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;
   localparam int          MODE_MSB  = CTRL_MODE_LSB + CTRL_MODE_W - 1;

   generate
      if (CRC_W < 16 || (CRC_W % 16) != 0) begin : g_bad_w
         $error("prog_crc32_engine: CRC_W must be a multiple of 16");
      end
      if (OFS_DATA >= ADDR_SPAN || OFS_CTRL >= ADDR_SPAN ||
          OFS_SEED >= ADDR_SPAN || OFS_POLY >= ADDR_SPAN) begin : g_bad_ofs
         $error("prog_crc32_engine: register offset outside address space");
      end
      if (OFS_DATA == OFS_CTRL || OFS_DATA == OFS_SEED || OFS_DATA == OFS_POLY ||
          OFS_CTRL == OFS_SEED || OFS_CTRL == OFS_POLY || OFS_SEED == OFS_POLY) begin : g_dup_ofs
         $error("prog_crc32_engine: register offsets must be distinct");
      end
   endgenerate

   // ---------------- state ----------------
   logic [CRC_W-1:0] acc_q;
   logic [CRC_W-1:0] seed_q;
   logic [CRC_W-1:0] poly_q;
   crc_mode_t        mode_q;

   // ---------------- decode ----------------
   logic hit_data, hit_ctrl, hit_seed, hit_poly;

   always_comb begin
      hit_data = (bus_addr == ADDR_W'(OFS_DATA));
      hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
      hit_seed = (bus_addr == ADDR_W'(OFS_SEED));
      hit_poly = (bus_addr == ADDR_W'(OFS_POLY));
   end

   // ---------------- datapath ----------------
   logic [CRC_W-1:0] data_swz;
   logic [CRC_W-1:0] acc_next;
   logic [CRC_W-1:0] acc_rev;

   pcrc_in_swizzle #(.W(CRC_W)) u_swz (
      .din  (bus_wdata),
      .mode (mode_q.in_rev),
      .dout (data_swz)
   );

   pcrc_fold #(.W(CRC_W)) u_fold (
      .crc_in  (acc_q),
      .data    (data_swz),
      .poly    (poly_q),
      .crc_out (acc_next)
   );

   pcrc_lane_reflect #(.W(CRC_W), .LANE(CRC_W)) u_out_rev (
      .din  (acc_q),
      .dout (acc_rev)
   );

   // ---------------- write side ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= CRC_W'(SEED_RST);
         seed_q <= CRC_W'(SEED_RST);
         poly_q <= CRC_W'(POLY_RST);
         mode_q <= '0;
      end else if (bus_wr_en) begin
         if (hit_data) begin
            acc_q <= acc_next;
         end
         if (hit_ctrl) begin
            mode_q <= crc_mode_t'(bus_wdata[MODE_MSB:CTRL_MODE_LSB]);
            if (bus_wdata[CTRL_RELOAD_BIT]) begin
               acc_q <= seed_q;
            end
         end
         if (hit_seed) begin
            seed_q <= bus_wdata;
         end
         if (hit_poly) begin
            poly_q <= bus_wdata;
         end
      end
   end

   // ---------------- read side ----------------
   logic [CRC_W-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      if (hit_data) begin
         rd_mux = mode_q.out_rev ? acc_rev : acc_q;
      end else if (hit_ctrl) begin
         rd_mux[MODE_MSB:CTRL_MODE_LSB] = mode_q;
      end else if (hit_seed) begin
         rd_mux = seed_q;
      end else if (hit_poly) begin
         rd_mux = poly_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd_en) begin
         bus_rdata <= rd_mux;
      end
   end
endmodule

module pcrc_chk #(
   parameter int          ADDR_W   = 8,
   parameter int          CRC_W    = 32,
   parameter int unsigned OFS_DATA = 'h00,
   parameter int unsigned OFS_CTRL = 'h08,
   parameter int unsigned OFS_SEED = 'h10,
   parameter int unsigned OFS_POLY = 'h14
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr_en,
   input logic              wr_reload,
   input logic              bus_rd_en,
   input logic [CRC_W-1:0]  bus_rdata,
   input logic [CRC_W-1:0]  acc_q,
   input logic [CRC_W-1:0]  seed_q
);
   logic is_mapped, is_ctrl, is_cfg;

   always_comb begin
      is_ctrl   = (32'(bus_addr) == OFS_CTRL);
      is_cfg    = (32'(bus_addr) == OFS_SEED) || (32'(bus_addr) == OFS_POLY);
      is_mapped = (32'(bus_addr) == OFS_DATA) || is_ctrl || is_cfg;
   end

   // R9
   unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_en && !is_mapped) |=> (bus_rdata == '0));

   // R9
   unmapped_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_en && !is_mapped) |=> ($stable(acc_q) && $stable(seed_q)));

   // R3
   ctrl_reload_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_en && is_ctrl) |=> (bus_rdata[4:0] == 5'd0));

   // R3
   reload_from_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_en && is_ctrl && wr_reload) |=> (acc_q == $past(seed_q)));

   // R8
   cfg_write_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_en && (is_cfg || (is_ctrl && !wr_reload))) |=> $stable(acc_q));

   // R8
   idle_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr_en |=> $stable(acc_q));

   // R11
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_en |=> $stable(bus_rdata));
endmodule

bind prog_crc32_engine pcrc_chk #(
   .ADDR_W   (ADDR_W),
   .CRC_W    (CRC_W),
   .OFS_DATA (OFS_DATA),
   .OFS_CTRL (OFS_CTRL),
   .OFS_SEED (OFS_SEED),
   .OFS_POLY (OFS_POLY)
) u_pcrc_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr_en (bus_wr_en),
   .wr_reload (bus_wdata[0]),
   .bus_rd_en (bus_rd_en),
   .bus_rdata (bus_rdata),
   .acc_q     (acc_q),
   .seed_q    (seed_q)
);

// File: tb/prog_crc32_engine_bench.sv
module prog_crc32_engine_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr_en = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd_en = 1'b0;
   logic [31:0] bus_rdata;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   prog_crc32_engine u_prog_crc32_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr_en (bus_wr_en),
      .bus_wdata (bus_wdata),
      .bus_rd_en (bus_rd_en),
      .bus_rdata (bus_rdata)
   );

   // ---------------- reference arithmetic ----------------
   function automatic logic [31:0] bitrev32(input logic [31:0] d);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = d[31-i];
      return r;
   endfunction

   function automatic logic [31:0] ref_swz(input logic [31:0] d, input int m);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) begin
         case (m)
            1:       r[i] = d[(i/8)*8 + 7 - (i%8)];
            2:       r[i] = d[(i/16)*16 + 15 - (i%16)];
            3:       r[i] = d[31 - i];
            default: r[i] = d[i];
         endcase
      end
      return r;
   endfunction

   function automatic logic [31:0] ref_msb(input logic [31:0] c, input logic [31:0] d,
                                           input logic [31:0] p);
      logic [31:0] r = c;
      for (int i = 31; i >= 0; i--) begin
         logic top = r[31] ^ d[i];
         r = r << 1;
         if (top) r = r ^ p;
      end
      return r;
   endfunction

   // bytewise little-endian, LSB-first reflected CRC register update
   function automatic logic [31:0] ref_lsb(input logic [31:0] c, input logic [31:0] d,
                                           input logic [31:0] rp);
      logic [31:0] r = c ^ d;
      for (int i = 0; i < 32; i++) r = r[0] ? ((r >> 1) ^ rp) : (r >> 1);
      return r;
   endfunction

   // ---------------- bus tasks ----------------
   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd_en = 1'b1;
      @(negedge clk);
      bus_rd_en = 1'b0;
      d = bus_rdata;
   endtask

   task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   localparam logic [7:0] A_DATA = 8'h00, A_CTRL = 8'h08, A_SEED = 8'h10, A_POLY = 8'h14;

   logic [31:0] pats [0:7] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hAAAA_AAAA, 32'h0000_0001,
                               32'h8000_0000, 32'h1234_5678, 32'hC0FF_EE01, 32'h0F1E_2D3C};

   initial begin
      logic [31:0] rd, model, hold;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      bus_read(A_DATA, rd); check32("R1 data reset", rd, 32'hFFFF_FFFF);
      bus_read(A_CTRL, rd); check32("R1 ctrl reset", rd, 32'h0);
      bus_read(A_SEED, rd); check32("R1 seed reset", rd, 32'hFFFF_FFFF);
      bus_read(A_POLY, rd); check32("R1 poly reset", rd, 32'h04C1_1DB7);

      // R10 seed and polynomial readback
      for (int i = 0; i < 8; i++) begin
         bus_write(A_SEED, pats[i] ^ 32'h5A5A_0000);
         bus_read(A_SEED, rd); check32("R10 seed readback", rd, pats[i] ^ 32'h5A5A_0000);
         bus_write(A_POLY, ~pats[i]);
         bus_read(A_POLY, rd); check32("R10 poly readback", rd, ~pats[i]);
      end

      // R2 R4 R5 sweep over all eight reflection settings
      for (int m = 0; m < 8; m++) begin
         bus_write(A_SEED, 32'h1357_9BDF + 32'(m));
         bus_write(A_POLY, 32'h04C1_1DB7 ^ (32'(m) << 9));
         bus_write(A_CTRL, (32'(m) << 5) | 32'h1);
         bus_read(A_CTRL, rd); check32("R3 R4 ctrl readback", rd, 32'(m) << 5);
         model = 32'h1357_9BDF + 32'(m);
         for (int i = 0; i < 8; i++) begin
            bus_write(A_DATA, pats[i]);
            model = ref_msb(model, ref_swz(pats[i], m & 3), 32'h04C1_1DB7 ^ (32'(m) << 9));
            bus_read(A_DATA, rd);
            check32("R2 R4 R5 fold", rd, (m >= 4) ? bitrev32(model) : model);
         end
      end

      // R6 reflected CRC-32
      bus_write(A_SEED, 32'hFFFF_FFFF);
      bus_write(A_POLY, 32'h04C1_1DB7);
      bus_write(A_CTRL, 32'hE1);
      model = 32'hFFFF_FFFF;
      for (int i = 0; i < 8; i++) begin
         bus_write(A_DATA, pats[7-i]);
         model = ref_lsb(model, pats[7-i], 32'hEDB8_8320);
         bus_read(A_DATA, rd); check32("R6 reflected crc32", rd, model);
      end

      // R7 CRC-32C after software inversion
      bus_write(A_POLY, 32'h1EDC_6F41);
      bus_write(A_CTRL, 32'hE1);
      model = 32'hFFFF_FFFF;
      for (int i = 0; i < 8; i++) begin
         bus_write(A_DATA, pats[i] + 32'h0101_0101);
         model = ref_lsb(model, pats[i] + 32'h0101_0101, 32'h82F6_3B78);
         bus_read(A_DATA, rd); check32("R7 crc32c inverted", ~rd, ~model);
      end

      // R8 config writes keep accumulator; new settings apply on next write
      bus_write(A_CTRL, 32'h01);
      bus_write(A_DATA, 32'hDEAD_BEEF);
      model = ref_msb(32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'h1EDC_6F41);
      bus_write(A_POLY, 32'h0000_0007);
      bus_write(A_SEED, 32'h0BAD_F00D);
      bus_write(A_CTRL, 32'h60);
      bus_write(A_CTRL, 32'h00);
      bus_read(A_DATA, rd); check32("R8 acc kept over config", rd, model);
      bus_write(A_DATA, 32'h0102_0304);
      model = ref_msb(model, 32'h0102_0304, 32'h0000_0007);
      bus_read(A_DATA, rd); check32("R8 new poly applied", rd, model);

      // R3 reload and self-clearing bit
      bus_write(A_CTRL, 32'h1F);
      bus_read(A_CTRL, rd); check32("R3 reload bit reads zero", rd, 32'h0);
      bus_read(A_DATA, rd); check32("R3 reload from seed", rd, 32'h0BAD_F00D);

      // R11 rdata holds without a read strobe
      hold = bus_rdata;
      bus_write(A_DATA, 32'h7777_0000);
      repeat (2) @(negedge clk);
      check32("R11 rdata held", bus_rdata, hold);
      bus_read(A_DATA, model);

      // R9 sweep of every offset
      for (int a = 0; a < 256; a++) begin
         if (a != 8'h00 && a != 8'h08 && a != 8'h10 && a != 8'h14) begin
            bus_write(8'(a), 32'hFFFF_FFFF);
            bus_read(8'(a), rd); check32("R9 unmapped read", rd, 32'h0);
         end
      end
      bus_read(A_DATA, rd); check32("R9 data untouched", rd, model);
      bus_read(A_SEED, rd); check32("R9 seed untouched", rd, 32'h0BAD_F00D);
      bus_read(A_POLY, rd); check32("R9 poly untouched", rd, 32'h0000_0007);
      bus_read(A_CTRL, rd); check32("R9 ctrl untouched", rd, 32'h0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule